// File: doc/BRIEF.md
# Pixel Stream Region and Color Tagger

This block rides next to the horizontal readout of an interline color CCD. Every time the pixel-clock enable is high, one sample leaves the sensor, and the block says what that sample is. Horizontally, a line has four bands in a fixed order: dummy prescan, then leading optical black, then the active pixels, then trailing optical black. A sample counter, cleared by the line-start strobe, places each sample in one of these bands. A line counter, cleared by the field-start strobe, places each line in a vertical band: blank, leading black rows, active rows, trailing black rows, then blank again.

For every sample that is active both horizontally and vertically, the block also gives the active column and row and a two-bit Bayer color tag. Sensor rows alternate between G/B content and R/G content. In field accumulation each output line is a summed pair of rows, and the pair type alternates from line to line. In frame accumulation one field carries only R/G rows and the other carries only G/B rows. A mode input, sampled at field start, selects which of these mappings applies. All outputs are combinational from the counters and the current enable, so they describe the sample that is present in the same cycle.

Top module: `pix_region_tagger`

## Requirements
- R1: With the sample index s counted from 0 since the last line start, region_o is 0 (prescan) for s < H_PRE, 1 (leading black) for the next H_OBL samples, 2 (active) for the next H_ACT samples, 3 (trailing black) for the next H_OBT samples, and 4 (past end) for every later sample.
- R2: The sample index advances only on cycles where pix_en_i is high. Once it reaches the end of the line it stays there until the next line start, so region_o stays at 4.
- R3: line_start_i clears the sample index to 0 for the next sample and adds one to the line index.
- R4: field_start_i sets the line index to 0, or to 1 when line_start_i is high in the same cycle, and latches mode_i. A change of mode_i between field starts has no effect on color_o.
- R5: With line index L, v_ob_o is high for 1 <= L <= V_OBL and for the V_OBT lines that follow the V_ACT active lines. v_act_o is high for the V_ACT lines after the leading black lines. Both are low at L = 0 and past the trailing black lines.
- R6: pix_vld_o is high exactly when pix_en_i is high, region_o is 2 and v_act_o is high. In that case col_o gives the active column (0 first) and row_o gives the active line (0 first). Otherwise both are 0.
- R7: Color codes are 1 = R, 2 = G and 3 = B. An R/G line gives R on even active columns and G on odd ones. A G/B line gives G on even columns and B on odd ones. Mode 0 (field) makes even active lines G/B and odd active lines R/G. Mode 1 (frame, odd field) makes every line R/G. Mode 2 (frame, even field) makes every line G/B.
- R8: color_o is 0 (reserved) whenever pix_vld_o is low.
- R9: Mode 3 is treated as mode 0.
- R10: After reset, with no strobe applied, a sample shows region_o = 0, v_ob_o = 0, v_act_o = 0, pix_vld_o = 0 and color_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | One sample is present this cycle |
| line_start_i | input | 1 | Start-of-line strobe |
| field_start_i | input | 1 | Start-of-field strobe |
| mode_i | input | 2 | Accumulation mode: 0 field, 1 frame odd, 2 frame even, 3 as 0 |
| region_o | output | 3 | Horizontal band of the current sample |
| v_ob_o | output | 1 | Current line is a vertical black row |
| v_act_o | output | 1 | Current line is an active line |
| pix_vld_o | output | 1 | Current sample is an active pixel |
| col_o | output | $clog2(H_ACT) | Active column |
| row_o | output | $clog2(V_ACT) | Active line |
| color_o | output | 2 | Bayer color tag |

## Verification
A sample counter that is off by one shifts every band edge, so the first black or active sample of the very next line already shows the wrong region_o, and col_o is wrong for the whole line. A wrong line count or a wrong latched mode does not fail until the first active pixel of the field: from then on the pattern of color_o has the wrong phase on every pixel. The test table therefore places samples exactly on band edges and on active lines of both parities in every mode, and the directed tests cover the strobes, holds and saturation that move the counters.

// File: rtl/pix_region_pkg.sv
package pix_region_pkg;
  typedef enum logic [2:0] {
    HR_PRE  = 3'd0,
    HR_OBL  = 3'd1,
    HR_ACT  = 3'd2,
    HR_OBT  = 3'd3,
    HR_IDLE = 3'd4
  } h_region_e;

  localparam logic [1:0] COL_NONE = 2'd0;
  localparam logic [1:0] COL_R    = 2'd1;
  localparam logic [1:0] COL_G    = 2'd2;
  localparam logic [1:0] COL_B    = 2'd3;

  localparam logic [1:0] MODE_FIELD = 2'd0;
  localparam logic [1:0] MODE_ODD   = 2'd1;
  localparam logic [1:0] MODE_EVEN  = 2'd2;
endpackage

// File: rtl/pix_h_count.sv
module pix_h_count
  import pix_region_pkg::*;
#(
  parameter int unsigned H_PRE = 22,
  parameter int unsigned H_OBL = 3,
  parameter int unsigned H_ACT = 1174,
  parameter int unsigned H_OBT = 40,
  parameter int unsigned ACW   = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pix_en_i,
  input  logic           line_start_i,
  output h_region_e      region_o,
  output logic [ACW-1:0] col_o
);
  localparam int unsigned TOT = H_PRE + H_OBL + H_ACT + H_OBT;
  localparam int unsigned CW  = $clog2(TOT + 1);
  localparam int unsigned E0  = H_PRE;
  localparam int unsigned E1  = E0 + H_OBL;
  localparam int unsigned E2  = E1 + H_ACT;
  localparam int unsigned E3  = E2 + H_OBT;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] off;

  always_comb begin
    cnt_d = cnt_q;
    if (line_start_i)                          cnt_d = '0;
    else if (pix_en_i && cnt_q != CW'(TOT))    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    if      (cnt_q < CW'(E0)) region_o = HR_PRE;
    else if (cnt_q < CW'(E1)) region_o = HR_OBL;
    else if (cnt_q < CW'(E2)) region_o = HR_ACT;
    else if (cnt_q < CW'(E3)) region_o = HR_OBT;
    else                      region_o = HR_IDLE;
  end

  assign off   = cnt_q - CW'(E1);
  assign col_o = ACW'(off);
endmodule

// File: rtl/pix_v_count.sv
module pix_v_count
  import pix_region_pkg::*;
#(
  parameter int unsigned V_OBL = 4,
  parameter int unsigned V_ACT = 442,
  parameter int unsigned V_OBT = 1,
  parameter int unsigned RW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_start_i,
  input  logic          field_start_i,
  input  logic [1:0]    mode_i,
  output logic          v_ob_o,
  output logic          v_act_o,
  output logic [RW-1:0] row_o,
  output logic          rg_line_o
);
  localparam int unsigned TOT = V_OBL + V_ACT + V_OBT;
  localparam int unsigned LW  = $clog2(TOT + 2);
  localparam int unsigned A0  = V_OBL + 1;
  localparam int unsigned A1  = A0 + V_ACT;
  localparam int unsigned T1  = A1 + V_OBT;

  logic [LW-1:0] line_q, line_d;
  logic [1:0]    mode_q;
  logic [LW-1:0] off;

  always_comb begin
    line_d = line_q;
    if (field_start_i)                            line_d = line_start_i ? LW'(1) : '0;
    else if (line_start_i && line_q != LW'(T1))   line_d = line_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      mode_q <= MODE_FIELD;
    end else begin
      line_q <= line_d;
      if (field_start_i) mode_q <= (mode_i == 2'd3) ? MODE_FIELD : mode_i;
    end
  end

  assign v_act_o = (line_q >= LW'(A0)) && (line_q < LW'(A1));
  assign v_ob_o  = ((line_q != '0) && (line_q < LW'(A0))) ||
                   ((line_q >= LW'(A1)) && (line_q < LW'(T1)));
  assign off     = line_q - LW'(A0);
  assign row_o   = RW'(off);

  always_comb begin
    unique case (mode_q)
      MODE_ODD:  rg_line_o = 1'b1;
      MODE_EVEN: rg_line_o = 1'b0;
      default:   rg_line_o = row_o[0];
    endcase
  end
endmodule

// File: rtl/pix_color_map.sv
module pix_color_map
  import pix_region_pkg::*;
(
  input  logic       vld_i,
  input  logic       rg_line_i,
  input  logic       col_odd_i,
  output logic [1:0] color_o
);
  always_comb begin
    if (!vld_i)         color_o = COL_NONE;
    else if (rg_line_i) color_o = col_odd_i ? COL_G : COL_R;
    else                color_o = col_odd_i ? COL_B : COL_G;
  end
endmodule

// File: rtl/pix_region_tagger.sv
module pix_region_tagger
  import pix_region_pkg::*;
#(
  parameter int unsigned H_PRE = 22,
  parameter int unsigned H_OBL = 3,
  parameter int unsigned H_ACT = 1174,
  parameter int unsigned H_OBT = 40,
  parameter int unsigned V_OBL = 4,
  parameter int unsigned V_ACT = 442,
  parameter int unsigned V_OBT = 1,
  localparam int unsigned ACW  = (H_ACT > 1) ? $clog2(H_ACT) : 1,
  localparam int unsigned RW   = (V_ACT > 1) ? $clog2(V_ACT) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pix_en_i,
  input  logic           line_start_i,
  input  logic           field_start_i,
  input  logic [1:0]     mode_i,
  output logic [2:0]     region_o,
  output logic           v_ob_o,
  output logic           v_act_o,
  output logic           pix_vld_o,
  output logic [ACW-1:0] col_o,
  output logic [RW-1:0]  row_o,
  output logic [1:0]     color_o
);
  h_region_e      h_reg;
  logic [ACW-1:0] h_col;
  logic [RW-1:0]  v_row;
  logic           rg_line;

  pix_h_count #(
    .H_PRE(H_PRE), .H_OBL(H_OBL), .H_ACT(H_ACT), .H_OBT(H_OBT), .ACW(ACW)
  ) h_cnt_i (
    .clk_i, .rst_ni, .pix_en_i, .line_start_i,
    .region_o(h_reg), .col_o(h_col)
  );

  pix_v_count #(
    .V_OBL(V_OBL), .V_ACT(V_ACT), .V_OBT(V_OBT), .RW(RW)
  ) v_cnt_i (
    .clk_i, .rst_ni, .line_start_i, .field_start_i, .mode_i,
    .v_ob_o, .v_act_o, .row_o(v_row), .rg_line_o(rg_line)
  );

  assign pix_vld_o = pix_en_i && (h_reg == HR_ACT) && v_act_o;
  assign region_o  = h_reg;
  assign col_o     = pix_vld_o ? h_col : '0;
  assign row_o     = pix_vld_o ? v_row : '0;

  pix_color_map color_i (
    .vld_i(pix_vld_o), .rg_line_i(rg_line), .col_odd_i(h_col[0]), .color_o
  );
endmodule

// File: rtl/pix_region_tagger_chk.sv
module pix_region_tagger_chk #(
  parameter int unsigned ACW = 11,
  parameter int unsigned RW  = 9
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           line_start_i,
  input logic           field_start_i,
  input logic [2:0]     region_o,
  input logic           v_ob_o,
  input logic           v_act_o,
  input logic           pix_vld_o,
  input logic [ACW-1:0] col_o,
  input logic [RW-1:0]  row_o,
  input logic [1:0]     color_o
);
  p_region_mono_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(line_start_i) |-> region_o >= $past(region_o));

  p_vband_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(v_ob_o && v_act_o));

  p_vld_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> (region_o == 3'd2) && v_act_o);

  p_col_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_o && $past(pix_vld_o) && !$past(line_start_i)) |-> col_o == $past(col_o) + 1'b1);

  p_color_alt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_o && $past(pix_vld_o) && !$past(line_start_i) && !$past(field_start_i))
      |-> (color_o != $past(color_o)) && (row_o == $past(row_o)));

  p_color_rsv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_o |-> color_o == 2'd0);
endmodule

bind pix_region_tagger pix_region_tagger_chk #(.ACW(ACW), .RW(RW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
  .field_start_i(field_start_i), .region_o(region_o), .v_ob_o(v_ob_o),
  .v_act_o(v_act_o), .pix_vld_o(pix_vld_o), .col_o(col_o), .row_o(row_o),
  .color_o(color_o)
);

// File: tb/pix_region_tagger_tb.sv
module pix_region_tagger_tb_top;
  localparam int CLK_PERIOD = 10;
  // small geometry: samples 0-2 pre, 3-4 black, 5-10 active, 11-12 black, 13+ end
  // lines 1-2 black, 3-6 active, 7 black
  localparam int HP = 3, HO = 2, HA = 6, HT = 2;
  localparam int VO = 2, VA = 4, VT = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_en = 1'b0, lstart = 1'b0, fstart = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] region;
  logic v_ob, v_act, pix_vld;
  logic [2:0] col;
  logic [1:0] row;
  logic [1:0] color;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_region_tagger #(
    .H_PRE(HP), .H_OBL(HO), .H_ACT(HA), .H_OBT(HT),
    .V_OBL(VO), .V_ACT(VA), .V_OBT(VT)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .line_start_i(lstart),
    .field_start_i(fstart), .mode_i(mode), .region_o(region), .v_ob_o(v_ob),
    .v_act_o(v_act), .pix_vld_o(pix_vld), .col_o(col), .row_o(row), .color_o(color)
  );

  typedef struct packed {
    logic [1:0] md;
    logic [7:0] ln;
    logic [7:0] smp;
    logic [2:0] rg;
    logic       vob;
    logic       vact;
    logic [1:0] clr;
    logic [7:0] cl;
    logic [7:0] rw;
  } vec_t;

  // mode, line, sample, region, v_ob, v_act, color, col, row
  localparam vec_t VEC [16] = '{
    '{2'd0, 8'd0, 8'd0,  3'd0, 1'b0, 1'b0, 2'd0, 8'd0, 8'd0},
    '{2'd0, 8'd1, 8'd3,  3'd1, 1'b1, 1'b0, 2'd0, 8'd0, 8'd0},
    '{2'd0, 8'd3, 8'd5,  3'd2, 1'b0, 1'b1, 2'd2, 8'd0, 8'd0},
    '{2'd0, 8'd3, 8'd6,  3'd2, 1'b0, 1'b1, 2'd3, 8'd1, 8'd0},
    '{2'd0, 8'd4, 8'd5,  3'd2, 1'b0, 1'b1, 2'd1, 8'd0, 8'd1},
    '{2'd0, 8'd4, 8'd10, 3'd2, 1'b0, 1'b1, 2'd2, 8'd5, 8'd1},
    '{2'd0, 8'd3, 8'd11, 3'd3, 1'b0, 1'b1, 2'd0, 8'd0, 8'd0},
    '{2'd0, 8'd6, 8'd12, 3'd3, 1'b0, 1'b1, 2'd0, 8'd0, 8'd0},
    '{2'd0, 8'd7, 8'd5,  3'd2, 1'b1, 1'b0, 2'd0, 8'd0, 8'd0},
    '{2'd0, 8'd8, 8'd5,  3'd2, 1'b0, 1'b0, 2'd0, 8'd0, 8'd0},
    '{2'd1, 8'd3, 8'd5,  3'd2, 1'b0, 1'b1, 2'd1, 8'd0, 8'd0},
    '{2'd1, 8'd4, 8'd6,  3'd2, 1'b0, 1'b1, 2'd2, 8'd1, 8'd1},
    '{2'd2, 8'd4, 8'd5,  3'd2, 1'b0, 1'b1, 2'd2, 8'd0, 8'd1},
    '{2'd2, 8'd5, 8'd6,  3'd2, 1'b0, 1'b1, 2'd3, 8'd1, 8'd2},
    '{2'd3, 8'd4, 8'd5,  3'd2, 1'b0, 1'b1, 2'd1, 8'd0, 8'd1},
    '{2'd0, 8'd3, 8'd13, 3'd4, 1'b0, 1'b1, 2'd0, 8'd0, 8'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic en, input logic ls, input logic fs);
    @(negedge clk);
    pix_en = en; lstart = ls; fstart = fs;
    @(negedge clk);
    pix_en = 1'b0; lstart = 1'b0; fstart = 1'b0;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 1'b0);
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b0);
  endtask

  // present one sample and look at the outputs before the edge that consumes it
  task automatic probe();
    @(negedge clk);
    pix_en = 1'b1;
    #1;
  endtask

  task automatic unprobe();
    @(negedge clk);
    pix_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    probe();
    chk("R10", "region", region, 0);
    chk("R10", "v_ob", v_ob, 0);
    chk("R10", "v_act", v_act, 0);
    chk("R10", "pix_vld", pix_vld, 0);
    chk("R10", "color", color, 0);
    unprobe();

    // table walk: R1 R5 R6 R7 R8 R9
    for (int k = 0; k < 16; k++) begin
      if (k > 0) begin
        @(negedge clk); mode = VEC[k].md;
        tick(1'b0, 1'b0, 1'b1);
        lines(int'(VEC[k].ln));
      end
      skip(int'(VEC[k].smp));
      probe();
      chk("R1", $sformatf("v%0d region", k), region, VEC[k].rg);
      chk("R5", $sformatf("v%0d v_ob", k), v_ob, VEC[k].vob);
      chk("R5", $sformatf("v%0d v_act", k), v_act, VEC[k].vact);
      chk("R6", $sformatf("v%0d col", k), col, VEC[k].cl);
      chk("R6", $sformatf("v%0d row", k), row, VEC[k].rw);
      chk(VEC[k].md == 2'd3 ? "R9" : (VEC[k].clr == 0 ? "R8" : "R7"),
          $sformatf("v%0d color", k), color, VEC[k].clr);
      unprobe();
    end

    // R2 no advance without enable
    @(negedge clk); mode = 2'd0;
    tick(1'b0, 1'b0, 1'b1);
    lines(3);
    repeat (5) tick(1'b0, 1'b0, 1'b0);
    skip(5);
    probe();
    chk("R2", "region after idle", region, 2);
    chk("R2", "col after idle", col, 0);
    unprobe();

    // R2 saturation past end of line
    skip(20);
    probe();
    chk("R2", "region saturated", region, 4);
    unprobe();

    // R3 line start clears sample index, advances line
    lines(1);
    probe();
    chk("R3", "region after line start", region, 0);
    chk("R3", "v_act line 4", v_act, 1);
    unprobe();

    // R4 mode latched only at field start
    @(negedge clk); mode = 2'd1;
    tick(1'b0, 1'b0, 1'b1);
    lines(3);
    @(negedge clk); mode = 2'd2;
    skip(5);
    probe();
    chk("R4", "color keeps latched mode", color, 1);
    unprobe();

    // R4 field start clears line index
    tick(1'b0, 1'b0, 1'b1);
    probe();
    chk("R4", "v_ob after field start", v_ob, 0);
    chk("R4", "v_act after field start", v_act, 0);
    unprobe();

    // R4 field start with line start gives line 1
    tick(1'b0, 1'b1, 1'b1);
    probe();
    chk("R4", "v_ob line 1", v_ob, 1);
    unprobe();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule